// File: doc/BRIEF.md
# Pin Port with Per-Pin Interrupt Detection

This block is a small general-purpose I/O port of `NUM_PINS` pins (eight by default). Software drives it through a plain register bus: a byte address, a write strobe, a 32-bit write word and a 32-bit read word. Reads are combinational from the address. Writes take effect at the clock edge on which the strobe is sampled. Each pin has a direction bit and an output data bit. The data bits can be changed one at a time, without a read-modify-write, through a write-only set register and a write-only clear register. Each pin also has a 2-bit pad setting that is only stored and read back.

Every pin input passes through a synchronizer. It then feeds its own trigger detector, which is set up by three bits:
- a sense bit selects edge or level detection;
- a polarity bit selects rising/high or falling/low;
- a both-edge bit, in edge mode, fires on either transition whatever the polarity says.

A detected trigger sets a raw flag. Software reads the flags from a read-only status register and clears them through a write-only register. The interrupt line is the OR of the raw flags gated by the per-pin enable bits.

Top module: `pinport_irq`

## Requirements
- R1: After reset every readable register reads 0, `pin_oe`, `pin_out` and `irq` are 0, and any address outside the map reads 0.
- R2: A write to offset 0x04 sets the direction bits, where 1 means output and 0 means input. `pin_oe` equals the direction bits and `pin_out` equals the stored output data bits from the edge after the write.
- R3: A read of offset 0x00 returns, for each pin, the output data bit if the pin is an output and the synchronized pin level if it is an input. A write to 0x00 loads the output data bits.
- R4: Writing to the set register (0x24) forces each data bit whose write bit is 1 to 1, and writing to the clear register (0x28) forces it to 0. Write bits of 0 leave data unchanged, and both registers read 0.
- R5: Offset 0x08 holds a 2-bit pad field per pin (pin k in bits 2k+1:2k) that reads back as written, reads 0 above bit 2·NUM_PINS-1, and changes no output.
- R6: With the sense bit (0x0C) at 0, the both-edge bit (0x10) at 0 and the polarity bit (0x14) at 0, a rising pin transition sets the pin's raw flag, and a falling one does not.
- R7: With the polarity bit at 1 in edge mode, a falling transition sets the flag and a rising one does not.
- R8: In edge mode, a both-edge bit of 1 makes either transition set the flag, whatever the polarity bit holds.
- R9: With the sense bit at 1, the flag is set on every cycle the synchronized pin sits at its active level (high for polarity 0, low for polarity 1). A clear made while that level holds does not stay in effect. The both-edge bit is ignored in this mode.
- R10: Writing 1 to a bit of 0x20 clears that raw flag, and writing 0 leaves it. If a trigger and a clear meet in the same cycle, the flag ends up set. The register reads 0.
- R11: The raw status register (0x1C) returns the flags, and writes to it change nothing.
- R12: `irq` is 1 exactly when some raw flag is 1 and its enable bit (0x18) is 1.
- R13: A pin change shows in a data read two clock edges later, and in the raw flag and `irq` three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write word |
| bus_rdata | output | DATA_W | Read word for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Driven output data |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = output) |
| pad_cfg | output | 2*NUM_PINS | Stored pad settings |
| irq | output | 1 | Masked, OR-reduced interrupt request |

## Verification
Register effects are due on the first edge after the write, so the bench drives every access on a falling edge and compares `bus_rdata`, `pin_out`, `pin_oe` and `irq` on the next falling edge. A pin change is due in a data read after two rising edges and in the flags and `irq` after three. The directed checks count those edges one by one, including one check taken a single edge early. The random phase runs a bench model that advances on the same rising edge as the design. Each falling edge then compares all outputs against that model, so every result is checked in the cycle it is due.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

   // register offsets; the bus decodes these exact byte addresses
   localparam logic [7:0] OFS_DATA  = 8'h00;
   localparam logic [7:0] OFS_MODE  = 8'h04;
   localparam logic [7:0] OFS_PAD   = 8'h08;
   localparam logic [7:0] OFS_SENSE = 8'h0C;
   localparam logic [7:0] OFS_BOTH  = 8'h10;
   localparam logic [7:0] OFS_POL   = 8'h14;
   localparam logic [7:0] OFS_IEN   = 8'h18;
   localparam logic [7:0] OFS_STAT  = 8'h1C;
   localparam logic [7:0] OFS_FCLR  = 8'h20;
   localparam logic [7:0] OFS_SET   = 8'h24;
   localparam logic [7:0] OFS_CLR   = 8'h28;

   localparam int unsigned PAD_FIELD_W = 2;

   // per-pin trigger setup handed from the register file to the detectors
   typedef struct packed {
      logic level;   // 1: level sensitive, 0: edge sensitive
      logic both;    // edge mode: fire on either transition
      logic low;     // 1: falling / low, 0: rising / high
   } trig_cfg_t;

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pinport_detect.sv
module pinport_detect
   import pinport_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl,
   input  trig_cfg_t           cfg [NUM_PINS],
   input  logic [NUM_PINS-1:0] clr,
   output logic [NUM_PINS-1:0] flags
);

   logic [NUM_PINS-1:0] lvl_d;
   logic [NUM_PINS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
         logic rise, fall, act_lvl;
         assign rise    = lvl[k] & ~lvl_d[k];
         assign fall    = ~lvl[k] & lvl_d[k];
         assign act_lvl = cfg[k].low ? ~lvl[k] : lvl[k];

         always_comb begin
            if (cfg[k].level)     hit[k] = act_lvl;
            else if (cfg[k].both) hit[k] = rise | fall;
            else if (cfg[k].low)  hit[k] = fall;
            else                  hit[k] = rise;
         end

         // a trigger in the same cycle as a clear keeps the flag set
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[k] <= 1'b0;
            else        flags[k] <= hit[k] | (flags[k] & ~clr[k]);
         end
      end
   endgenerate

endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
   import pinport_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          we,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   input  logic [NUM_PINS-1:0]           pin_lvl,
   input  logic [NUM_PINS-1:0]           flags,
   output logic [NUM_PINS-1:0]           flag_clr,
   output logic [NUM_PINS-1:0]           mode,
   output logic [NUM_PINS-1:0]           dout,
   output logic [PAD_FIELD_W*NUM_PINS-1:0] pad,
   output logic [NUM_PINS-1:0]           ien,
   output trig_cfg_t                     cfg [NUM_PINS]
);

   localparam int unsigned PAD_W = PAD_FIELD_W * NUM_PINS;

   logic [NUM_PINS-1:0] sense_q, both_q, pol_q;
   logic [NUM_PINS-1:0] wbits;
   logic [PAD_W-1:0]    wpad;

   logic hit_data, hit_mode, hit_pad, hit_sense, hit_both, hit_pol;
   logic hit_ien, hit_stat, hit_fclr, hit_set, hit_clr;

   assign wbits = wdata[NUM_PINS-1:0];
   assign wpad  = wdata[PAD_W-1:0];

   generate
      if (PAD_W < DATA_W) begin : g_spare
         logic wdata_unused;
         assign wdata_unused = ^wdata[DATA_W-1:PAD_W];
      end
   endgenerate

   assign hit_data  = (addr == ADDR_W'(OFS_DATA));
   assign hit_mode  = (addr == ADDR_W'(OFS_MODE));
   assign hit_pad   = (addr == ADDR_W'(OFS_PAD));
   assign hit_sense = (addr == ADDR_W'(OFS_SENSE));
   assign hit_both  = (addr == ADDR_W'(OFS_BOTH));
   assign hit_pol   = (addr == ADDR_W'(OFS_POL));
   assign hit_ien   = (addr == ADDR_W'(OFS_IEN));
   assign hit_stat  = (addr == ADDR_W'(OFS_STAT));
   assign hit_fclr  = (addr == ADDR_W'(OFS_FCLR));
   assign hit_set   = (addr == ADDR_W'(OFS_SET));
   assign hit_clr   = (addr == ADDR_W'(OFS_CLR));

   // plain read-write configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= '0;
         pad     <= '0;
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         ien     <= '0;
      end else if (we) begin
         if (hit_mode)  mode    <= wbits;
         if (hit_pad)   pad     <= wpad;
         if (hit_sense) sense_q <= wbits;
         if (hit_both)  both_q  <= wbits;
         if (hit_pol)   pol_q   <= wbits;
         if (hit_ien)   ien     <= wbits;
      end
   end

   // output data with full-word load and per-bit set / clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (we) begin
         if (hit_data)     dout <= wbits;
         else if (hit_set) dout <= dout | wbits;
         else if (hit_clr) dout <= dout & ~wbits;
      end
   end

   assign flag_clr = (we && hit_fclr) ? wbits : '0;

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_cfg
         assign cfg[k] = '{level: sense_q[k], both: both_q[k], low: pol_q[k]};
      end
   endgenerate

   // combinational read; write-only and unmapped addresses return zero
   always_comb begin
      rdata = '0;
      unique case (1'b1)
         hit_data:  rdata[NUM_PINS-1:0] = (mode & dout) | (~mode & pin_lvl);
         hit_mode:  rdata[NUM_PINS-1:0] = mode;
         hit_pad:   rdata[PAD_W-1:0]    = pad;
         hit_sense: rdata[NUM_PINS-1:0] = sense_q;
         hit_both:  rdata[NUM_PINS-1:0] = both_q;
         hit_pol:   rdata[NUM_PINS-1:0] = pol_q;
         hit_ien:   rdata[NUM_PINS-1:0] = ien;
         hit_stat:  rdata[NUM_PINS-1:0] = flags;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/pinport_irq.sv
module pinport_irq
   import pinport_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic [2*NUM_PINS-1:0] pad_cfg,
   output logic                  irq
);

   generate
      if (NUM_PINS < 1 || PAD_FIELD_W * NUM_PINS > DATA_W) begin : g_bad_pins
         $error("pinport_irq: NUM_PINS must fit its pad fields in DATA_W");
      end
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("pinport_irq: ADDR_W must lie in 6..8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pinport_irq: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_lvl;
   logic [NUM_PINS-1:0] raw_flags;
   logic [NUM_PINS-1:0] flag_clr;
   logic [NUM_PINS-1:0] irq_en;
   trig_cfg_t           trig_cfg [NUM_PINS];

   pinport_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_lvl)
   );

   pinport_regs #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .pin_lvl  (pin_lvl),
      .flags    (raw_flags),
      .flag_clr (flag_clr),
      .mode     (pin_oe),
      .dout     (pin_out),
      .pad      (pad_cfg),
      .ien      (irq_en),
      .cfg      (trig_cfg)
   );

   pinport_detect #(
      .NUM_PINS (NUM_PINS)
   ) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_lvl),
      .cfg   (trig_cfg),
      .clr   (flag_clr),
      .flags (raw_flags)
   );

   assign irq = |(raw_flags & irq_en);

endmodule

// File: rtl/pinport_irq_chk.sv
module pinport_irq_chk
   import pinport_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [NUM_PINS-1:0] wr_bits,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq,
   input logic [NUM_PINS-1:0] flags,
   input logic [NUM_PINS-1:0] ien
);

   // R1: the edge after a reset sample leaves the interrupt low
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> !irq);

   // R2: direction write lands on the enables one edge later
   a_r2_oe_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_MODE)) |=> (pin_oe == $past(wr_bits)));

   // R4: set write forces every selected bit high
   a_r4_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_SET))
         |=> ((pin_out & $past(wr_bits)) == $past(wr_bits)));

   // R4: clear write forces every selected bit low
   a_r4_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_CLR))
         |=> ((pin_out & $past(wr_bits)) == '0));

   // R10: an all-zero flag clear removes no flag
   a_r10_zero_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_FCLR) && wr_bits == '0)
         |=> ((flags & $past(flags)) == $past(flags)));

   // R12: an interrupt needs at least one enabled pin
   a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien != '0));

endmodule

bind pinport_irq pinport_irq_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .wr_bits  (bus_wdata[NUM_PINS-1:0]),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .irq      (irq),
   .flags    (raw_flags),
   .ien      (irq_en)
);

// File: tb/pinport_irq_bench.sv
`timescale 1ns/1ps
module pinport_irq_bench;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe;
   logic [2*N-1:0] pad_cfg;
   logic        irq;

   int vectors = 0;
   int fails   = 0;

   always #2.5 clk = ~clk;

   pinport_irq u_pinport_irq (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pad_cfg(pad_cfg), .irq(irq)
   );

   // ---------------- bench model built from the requirements ----------------
   logic [N-1:0] m_mode, m_dout, m_sense, m_both, m_pol, m_ien, m_flags;
   logic [N-1:0] m_s1, m_s2, m_prev;
   logic [2*N-1:0] m_pad;

   function automatic logic [N-1:0] f_trig(logic [N-1:0] s, logic [N-1:0] p);
      logic [N-1:0] r;
      for (int k = 0; k < N; k++) begin
         if (m_sense[k])     r[k] = m_pol[k] ? ~s[k] : s[k];
         else if (m_both[k]) r[k] = s[k] ^ p[k];
         else if (m_pol[k])  r[k] = p[k] & ~s[k];
         else                r[k] = s[k] & ~p[k];
      end
      return r;
   endfunction

   function automatic logic [31:0] f_read(logic [7:0] a);
      case (a)
         8'h00: return {24'h0, (m_mode & m_dout) | (~m_mode & m_s2)};
         8'h04: return {24'h0, m_mode};
         8'h08: return {16'h0, m_pad};
         8'h0C: return {24'h0, m_sense};
         8'h10: return {24'h0, m_both};
         8'h14: return {24'h0, m_pol};
         8'h18: return {24'h0, m_ien};
         8'h1C: return {24'h0, m_flags};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode <= '0; m_dout <= '0; m_sense <= '0; m_both <= '0; m_pol <= '0;
         m_ien <= '0; m_flags <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
         m_pad <= '0;
      end else begin
         logic [N-1:0] clrv;
         clrv = (bus_we && bus_addr == 8'h20) ? bus_wdata[N-1:0] : '0;
         m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
         m_flags <= f_trig(m_s2, m_prev) | (m_flags & ~clrv);
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_dout  <= bus_wdata[N-1:0];
               8'h04: m_mode  <= bus_wdata[N-1:0];
               8'h08: m_pad   <= bus_wdata[2*N-1:0];
               8'h0C: m_sense <= bus_wdata[N-1:0];
               8'h10: m_both  <= bus_wdata[N-1:0];
               8'h14: m_pol   <= bus_wdata[N-1:0];
               8'h18: m_ien   <= bus_wdata[N-1:0];
               8'h24: m_dout  <= m_dout | bus_wdata[N-1:0];
               8'h28: m_dout  <= m_dout & ~bus_wdata[N-1:0];
               default: ;
            endcase
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // all helpers start and end just after a falling edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic edges(int n);
      repeat (n) @(negedge clk);
   endtask

   logic [31:0] rv;

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] offs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};
      void'($urandom(32'h5EED_1234));
      edges(3);
      rst_n = 1'b1;
      edges(1);

      // R1: reset state, including an unmapped address
      foreach (offs[i]) begin rd(offs[i], rv); chk("R1 reset read", rv, 32'h0); end
      rd(8'h3C, rv); chk("R1 unmapped read", rv, 32'h0);
      chk("R1 irq/oe/out", {23'h0, irq, pin_oe, pin_out}, 32'h0);

      // R2, R3: direction and data mux
      wr(8'h04, 32'h0F); wr(8'h00, 32'hA5);
      chk("R2 pin_oe", {24'h0, pin_oe}, 32'h0F);
      chk("R2 pin_out", {24'h0, pin_out}, 32'hA5);
      pin_in = 8'h30;
      edges(1); rd(8'h00, rv); chk("R13 one edge early", rv, 32'h05);
      edges(1); rd(8'h00, rv); chk("R3 R13 data mux", rv, 32'h35);

      // R4: atomic set and clear
      wr(8'h24, 32'h50); chk("R4 set", {24'h0, pin_out}, 32'hF5);
      wr(8'h28, 32'h81); chk("R4 clear", {24'h0, pin_out}, 32'h74);
      wr(8'h24, 32'h00); chk("R4 zero set", {24'h0, pin_out}, 32'h74);
      rd(8'h24, rv); chk("R4 set reads 0", rv, 32'h0);

      // R5: pad fields
      wr(8'h08, 32'hFFFF_C3A1); rd(8'h08, rv); chk("R5 pad readback", rv, 32'h0000_C3A1);
      chk("R5 pad port", {16'h0, pad_cfg}, 32'hC3A1);
      chk("R5 no effect", {16'h0, pin_oe, pin_out}, 32'h0F74);

      pin_in = 8'h00; edges(4); wr(8'h20, 32'hFF); wr(8'h18, 32'hFF);
      rd(8'h1C, rv); chk("R10 flags cleared", rv, 32'h0);

      // R6: rising edge on pin 0, flag after three edges
      pin_in[0] = 1'b1;
      edges(2); rd(8'h1C, rv); chk("R13 flag not yet", rv, 32'h0);
      edges(1); rd(8'h1C, rv); chk("R6 R13 rising sets", rv, 32'h01);
      chk("R12 irq up", {31'h0, irq}, 32'h1);
      wr(8'h20, 32'h01); pin_in[0] = 1'b0; edges(4);
      rd(8'h1C, rv); chk("R6 falling ignored", rv, 32'h0);

      // R7: pin 1 falling with polarity 1
      wr(8'h14, 32'h02); pin_in[1] = 1'b1; edges(4);
      rd(8'h1C, rv); chk("R7 rising ignored", rv, 32'h0);
      pin_in[1] = 1'b0; edges(4);
      rd(8'h1C, rv); chk("R7 falling sets", rv, 32'h02);
      wr(8'h20, 32'h02);

      // R8: pin 2 both edges overrides polarity
      wr(8'h14, 32'h06); wr(8'h10, 32'h04);
      pin_in[2] = 1'b1; edges(4);
      rd(8'h1C, rv); chk("R8 rising with pol 1", rv, 32'h04);
      wr(8'h20, 32'h04); pin_in[2] = 1'b0; edges(4);
      rd(8'h1C, rv); chk("R8 falling", rv, 32'h04);
      wr(8'h20, 32'h04); wr(8'h14, 32'h00); wr(8'h10, 32'h00);

      // R9: pin 3 level high, clear does not stick
      wr(8'h0C, 32'h08); pin_in[3] = 1'b1; edges(4);
      wr(8'h20, 32'h08); edges(1);
      rd(8'h1C, rv); chk("R9 level persists", rv, 32'h08);
      pin_in[3] = 1'b0; edges(4); wr(8'h20, 32'h08);
      rd(8'h1C, rv); chk("R9 released clears", rv, 32'h0);
      wr(8'h0C, 32'h00);

      // R10: clear in the same cycle as a trigger keeps the flag
      pin_in[4] = 1'b1; edges(2);
      wr(8'h20, 32'h10);
      rd(8'h1C, rv); chk("R10 set wins over clear", rv, 32'h10);
      wr(8'h20, 32'h00); rd(8'h1C, rv); chk("R10 zero clear", rv, 32'h10);
      rd(8'h20, rv); chk("R10 clear reads 0", rv, 32'h0);

      // R11: status is read-only
      wr(8'h1C, 32'hFF); rd(8'h1C, rv); chk("R11 write ignored", rv, 32'h10);

      // R12: masking
      wr(8'h18, 32'hEF); chk("R12 masked", {31'h0, irq}, 32'h0);
      wr(8'h18, 32'h10); chk("R12 enabled", {31'h0, irq}, 32'h1);

      // random phase checked against the bench model (R2 R3 R5 R6 to R12)
      for (int i = 0; i < 6000; i++) begin
         chk("R3 R11 random read", bus_rdata, f_read(bus_addr));
         chk("R12 random irq", {31'h0, irq}, {31'h0, |(m_flags & m_ien)});
         chk("R2 R4 random pins", {16'h0, pin_oe, pin_out}, {16'h0, m_mode, m_dout});
         if (($urandom % 16) == 0) bus_addr = 8'h2C + 8'(($urandom % 4) * 4);
         else bus_addr = offs[$urandom % 11];
         bus_we    = ($urandom % 2) == 1;
         bus_wdata = $urandom;
         if (($urandom % 4) == 0) pin_in = 8'($urandom);
         @(negedge clk);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule